// File: doc/BRIEF.md
# Framed Parity Receiver with Acknowledge

This block sits behind a symbol classifier on a single-wire serial link. Each incoming symbol arrives as a one-cycle strobe with a kind (zero, one, delimiter, invalid) and the measured length of that symbol in clock cycles. The receiver assembles those symbols into frames and checks each frame's length and its two parity bits. A good frame is steered by its leading tag bit, either to a converter-code write or to a configuration register write.

A frame opens with a delimiter. A tag bit follows, then a 16-bit payload sent most significant bit first, then a high-slice parity bit and a low-slice parity bit. A closing delimiter ends the frame. Any delimiter empties the frame buffer, and the closing delimiter of one frame also opens the next. The block reports the result of each frame on three strobes: good frame, framing error and parity error.

When its enable input is set, the block answers each good frame with an active-low acknowledge pulse. The timing of that pulse is derived from the measured length of the final parity symbol.

Top module: `ack_frame_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every strobe output is low and `ack_n_o` is high.
- R2: A delimiter (kind 2) empties the frame buffer and opens a frame. A delimiter arriving with an empty buffer, including one that directly follows another delimiter, raises no strobe.
- R3: A good frame whose tag is 0 pulses `dac_we_o` and `frame_ok_o` for one cycle, in the cycle after the closing delimiter is sampled. In that cycle `dac_code_o` carries the 16 payload bits, with the first received bit as bit 15.
- R4: A good frame whose tag is 1 pulses `reg_we_o` and `frame_ok_o` in that same cycle. The first payload byte appears on `reg_addr_o` and the second on `reg_data_o`.
- R5: The first parity symbol must be 1 exactly when the tag plus the first payload byte hold an even number of ones. The second must be 1 exactly when the second payload byte holds an even number of ones.
- R6: A frame of correct length that breaks R5 in either slice pulses `parity_err_o` instead. It raises neither `frame_ok_o` nor any write strobe.
- R7: `frame_err_o` pulses in the cycle after the offending symbol in three cases: an invalid symbol (kind 3) inside an open frame, a closing delimiter after fewer than 19 bit symbols, and a closing delimiter after more than 19. An invalid symbol also closes the frame.
- R8: With `ack_en_i` high, let P be the `sym_len_i` of the last parity symbol. Take the cycle in which `frame_ok_o` is high as cycle 0. `ack_n_o` is then low from cycle 1+floor(P/4) through cycle floor(P/4)+floor(P/2)+P, and high otherwise within 2P+1 cycles.
- R9: A good frame seen with `ack_en_i` low produces no acknowledge, and it cancels any acknowledge still running.
- R10: Bit symbols (kinds 0 and 1) and invalid symbols that arrive while no frame is open are ignored and raise no strobe.
- R11: The closing delimiter of one frame opens the next, so frames can be sent back to back without extra delimiters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_vld_i | input | 1 | One-cycle strobe marking a classified symbol |
| sym_kind_i | input | 2 | Symbol kind: 0 zero, 1 one, 2 delimiter, 3 invalid |
| sym_len_i | input | PER_W | Measured length of the symbol in clock cycles |
| ack_en_i | input | 1 | Enables the acknowledge pulse |
| dac_we_o | output | 1 | Converter-code write strobe |
| dac_code_o | output | PAY_W | Converter code |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | PAY_W/2 | Register address |
| reg_data_o | output | PAY_W/2 | Register data |
| frame_ok_o | output | 1 | Good-frame strobe |
| frame_err_o | output | 1 | Framing-error strobe |
| parity_err_o | output | 1 | Parity-error strobe |
| ack_n_o | output | 1 | Acknowledge, active low, open-drain style |

## Verification
The bench builds the block with `PER_W` set to 8 and the default 16-bit payload. The narrow length field keeps the acknowledge window short enough to measure its start and width cycle by cycle. The table walk sends frames to both destinations with all-zero, all-one and mixed payloads. It also corrupts either parity slice or both, so each slice is shown to be checked on its own. Directed cases cover too-short and too-long frames, invalid symbols inside a frame and outside one, repeated delimiters, back-to-back frames, and an acknowledge with the enable on and with it off.

// File: rtl/afr_pkg.sv
package afr_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO  = 2'd0,
    SYM_ONE   = 2'd1,
    SYM_DELIM = 2'd2,
    SYM_BAD   = 2'd3
  } sym_kind_e;
endpackage

// File: rtl/rx_framer.sv
module rx_framer
  import afr_pkg::*;
#(
  parameter int PER_W     = 16,
  parameter int FRAME_LEN = 19
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sym_vld_i,
  input  logic [1:0]           sym_kind_i,
  input  logic [PER_W-1:0]     sym_len_i,
  output logic                 close_o,
  output logic                 bad_o,
  output logic [FRAME_LEN-1:0] bits_o,
  output logic [PER_W-1:0]     per_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_LEN + 1);

  sym_kind_e          kind;
  logic               open_q;
  logic [CNT_W-1:0]   cnt_q;

  assign kind = sym_kind_e'(sym_kind_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      cnt_q   <= '0;
      close_o <= 1'b0;
      bad_o   <= 1'b0;
      bits_o  <= '0;
      per_o   <= '0;
    end else begin
      close_o <= 1'b0;
      bad_o   <= 1'b0;
      if (sym_vld_i) begin
        unique case (kind)
          SYM_DELIM: begin
            if (open_q && cnt_q == FULL)       close_o <= 1'b1;
            else if (open_q && cnt_q != '0)    bad_o   <= 1'b1;
            open_q <= 1'b1;
            cnt_q  <= '0;
          end
          SYM_BAD: begin
            if (open_q) bad_o <= 1'b1;
            open_q <= 1'b0;
            cnt_q  <= '0;
          end
          default: begin
            if (open_q) begin
              bits_o <= {bits_o[FRAME_LEN-2:0], sym_kind_i[0]};
              per_o  <= sym_len_i;
              if (cnt_q != OVER) cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/frame_judge.sv
module frame_judge #(
  parameter int PAY_W = 16
) (
  input  logic               close_i,
  input  logic               bad_i,
  input  logic [PAY_W+2:0]   bits_i,
  output logic               dac_we_o,
  output logic [PAY_W-1:0]   dac_code_o,
  output logic               reg_we_o,
  output logic [PAY_W/2-1:0] reg_addr_o,
  output logic [PAY_W/2-1:0] reg_data_o,
  output logic               frame_ok_o,
  output logic               frame_err_o,
  output logic               parity_err_o
);
  localparam int HALF = PAY_W / 2;

  logic             tag;
  logic [PAY_W-1:0] pay;
  logic             hi_ok, lo_ok;

  assign tag = bits_i[PAY_W+2];
  assign pay = bits_i[PAY_W+1:2];
  // each slice plus its parity bit must hold an odd count of ones
  assign hi_ok = ^{tag, pay[PAY_W-1:HALF], bits_i[1]};
  assign lo_ok = ^{pay[HALF-1:0], bits_i[0]};

  assign frame_ok_o   = close_i & hi_ok & lo_ok;
  assign parity_err_o = close_i & ~(hi_ok & lo_ok);
  assign frame_err_o  = bad_i;
  assign dac_we_o     = frame_ok_o & ~tag;
  assign reg_we_o     = frame_ok_o & tag;
  assign dac_code_o   = pay;
  assign reg_addr_o   = pay[PAY_W-1:HALF];
  assign reg_data_o   = pay[HALF-1:0];
endmodule

// File: rtl/ack_gen.sv
module ack_gen #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ok_i,
  input  logic             ack_en_i,
  input  logic [PER_W-1:0] per_i,
  output logic             ack_n_o
);
  localparam int TW = PER_W + 1;

  logic          busy_q;
  logic [TW-1:0] cnt_q, lo_q, hi_q, end_q;
  logic [TW-1:0] per_x;

  assign per_x = {1'b0, per_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      end_q  <= '0;
    end else if (frame_ok_i) begin
      busy_q <= ack_en_i && (per_i != '0);
      cnt_q  <= '0;
      lo_q   <= per_x >> 2;
      hi_q   <= per_x + (per_x >> 1) + (per_x >> 2);
      end_q  <= per_x << 1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + TW'(1);
      if (cnt_q + TW'(1) == end_q) busy_q <= 1'b0;
    end
  end

  assign ack_n_o = ~(busy_q && cnt_q >= lo_q && cnt_q < hi_q);
endmodule

// File: rtl/ack_frame_rx.sv
module ack_frame_rx #(
  parameter int PER_W = 16,
  parameter int PAY_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sym_vld_i,
  input  logic [1:0]         sym_kind_i,
  input  logic [PER_W-1:0]   sym_len_i,
  input  logic               ack_en_i,
  output logic               dac_we_o,
  output logic [PAY_W-1:0]   dac_code_o,
  output logic               reg_we_o,
  output logic [PAY_W/2-1:0] reg_addr_o,
  output logic [PAY_W/2-1:0] reg_data_o,
  output logic               frame_ok_o,
  output logic               frame_err_o,
  output logic               parity_err_o,
  output logic               ack_n_o
);
  localparam int FRAME_LEN = PAY_W + 3;

  logic                 close, bad;
  logic [FRAME_LEN-1:0] bits;
  logic [PER_W-1:0]     per;

  rx_framer #(.PER_W(PER_W), .FRAME_LEN(FRAME_LEN)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sym_vld_i  (sym_vld_i),
    .sym_kind_i (sym_kind_i),
    .sym_len_i  (sym_len_i),
    .close_o    (close),
    .bad_o      (bad),
    .bits_o     (bits),
    .per_o      (per)
  );

  frame_judge #(.PAY_W(PAY_W)) u_judge (
    .close_i      (close),
    .bad_i        (bad),
    .bits_i       (bits),
    .dac_we_o     (dac_we_o),
    .dac_code_o   (dac_code_o),
    .reg_we_o     (reg_we_o),
    .reg_addr_o   (reg_addr_o),
    .reg_data_o   (reg_data_o),
    .frame_ok_o   (frame_ok_o),
    .frame_err_o  (frame_err_o),
    .parity_err_o (parity_err_o)
  );

  ack_gen #(.PER_W(PER_W)) u_ack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_ok_i (frame_ok_o),
    .ack_en_i   (ack_en_i),
    .per_i      (per),
    .ack_n_o    (ack_n_o)
  );
endmodule

// File: rtl/ack_frame_rx_chk.sv
module ack_frame_rx_chk #(
  parameter int PER_W = 16,
  parameter int PAY_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sym_vld_i,
  input logic [1:0]         sym_kind_i,
  input logic [PER_W-1:0]   sym_len_i,
  input logic               ack_en_i,
  input logic               dac_we_o,
  input logic [PAY_W-1:0]   dac_code_o,
  input logic               reg_we_o,
  input logic [PAY_W/2-1:0] reg_addr_o,
  input logic [PAY_W/2-1:0] reg_data_o,
  input logic               frame_ok_o,
  input logic               frame_err_o,
  input logic               parity_err_o,
  input logic               ack_n_o
);
  // R6
  ok_perr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_ok_o && parity_err_o));

  // R6
  perr_nowe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> !dac_we_o && !reg_we_o);

  // R7
  ferr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !frame_ok_o && !parity_err_o);

  // R3
  dac_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_we_o |-> frame_ok_o && !reg_we_o);

  // R4
  reg_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> frame_ok_o);

  // R9
  ack_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o && !ack_en_i |=> ack_n_o);

  // R2
  strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ok_o || frame_err_o || parity_err_o) |-> $past(sym_vld_i));
endmodule

bind ack_frame_rx ack_frame_rx_chk #(.PER_W(PER_W), .PAY_W(PAY_W)) u_chk (.*);

// File: tb/sim_ack_frame_rx.sv
`timescale 1ns/1ps
module sim_ack_frame_rx;
  localparam int PER_W = 8;
  localparam int PAY_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sym_vld_i = 1'b0;
  logic [1:0]       sym_kind_i = 2'd0;
  logic [PER_W-1:0] sym_len_i = '0;
  logic             ack_en_i = 1'b0;
  logic             dac_we_o, reg_we_o, frame_ok_o, frame_err_o, parity_err_o, ack_n_o;
  logic [15:0]      dac_code_o;
  logic [7:0]       reg_addr_o, reg_data_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ack_frame_rx #(.PER_W(PER_W), .PAY_W(PAY_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sym_vld_i(sym_vld_i), .sym_kind_i(sym_kind_i),
    .sym_len_i(sym_len_i), .ack_en_i(ack_en_i), .dac_we_o(dac_we_o),
    .dac_code_o(dac_code_o), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
    .reg_data_o(reg_data_o), .frame_ok_o(frame_ok_o), .frame_err_o(frame_err_o),
    .parity_err_o(parity_err_o), .ack_n_o(ack_n_o)
  );

  // {flip_hi, flip_lo, tag, payload}
  localparam logic [18:0] VEC [8] = '{
    {2'b00, 1'b0, 16'h0000}, {2'b00, 1'b0, 16'hFFFF},
    {2'b00, 1'b0, 16'hA5C3}, {2'b00, 1'b1, 16'h3C7E},
    {2'b00, 1'b1, 16'h0180}, {2'b10, 1'b0, 16'h1234},
    {2'b01, 1'b1, 16'h55AA}, {2'b11, 1'b0, 16'h8001}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_sym(input logic [1:0] kind, input int per);
    @(negedge clk);
    sym_vld_i  = 1'b1;
    sym_kind_i = kind;
    sym_len_i  = PER_W'(per);
    @(negedge clk);
    sym_vld_i  = 1'b0;
  endtask

  task automatic strobes_quiet(input string req);
    logic [4:0] s;
    s = {dac_we_o, reg_we_o, frame_ok_o, frame_err_o, parity_err_o};
    chk(s == 5'b0, req, 32'(s), 32'h0);
  endtask

  task automatic send_frame(input bit tag, input logic [15:0] pay, input bit f1, input bit f0,
                            input int per, input bit lead);
    logic p1, p0;
    p1 = ~(^{tag, pay[15:8]}) ^ f1;
    p0 = ~(^pay[7:0]) ^ f0;
    if (lead) send_sym(2'd2, per);
    send_sym({1'b0, tag}, per);
    for (int b = 15; b >= 0; b--) send_sym({1'b0, pay[b]}, per);
    send_sym({1'b0, p1}, per);
    send_sym({1'b0, p0}, per);
    send_sym(2'd2, per);
  endtask

  task automatic check_good(input bit tag, input logic [15:0] pay, input string req);
    chk(frame_ok_o && !parity_err_o && !frame_err_o, req, 32'(frame_ok_o), 32'h1);
    if (!tag) begin
      chk(dac_we_o && !reg_we_o, req, 32'({dac_we_o, reg_we_o}), 32'h2);
      chk(dac_code_o == pay, req, 32'(dac_code_o), 32'(pay));
    end else begin
      chk(reg_we_o && !dac_we_o, req, 32'({dac_we_o, reg_we_o}), 32'h1);
      chk({reg_addr_o, reg_data_o} == pay, req, 32'({reg_addr_o, reg_data_o}), 32'(pay));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int first, lows;
    repeat (3) @(negedge clk);
    // R1 during reset
    strobes_quiet("R1 in reset");
    chk(ack_n_o == 1'b1, "R1 ack in reset", 32'(ack_n_o), 32'h1);
    rst_ni = 1'b1;
    @(negedge clk);
    strobes_quiet("R1 after reset");
    chk(ack_n_o == 1'b1, "R1 ack after reset", 32'(ack_n_o), 32'h1);

    // R10: bit and invalid symbols with no frame open
    send_sym(2'd1, 8); strobes_quiet("R10 idle one");
    send_sym(2'd0, 8); strobes_quiet("R10 idle zero");
    send_sym(2'd3, 8); strobes_quiet("R10 idle invalid");

    // R2: repeated delimiters, then a frame
    send_sym(2'd2, 8); strobes_quiet("R2 first delim");
    send_sym(2'd2, 8); strobes_quiet("R2 second delim");
    send_frame(1'b0, 16'hBEEF, 1'b0, 1'b0, 8, 1'b1);
    check_good(1'b0, 16'hBEEF, "R2 frame after delims");

    // R11: next frame opened by previous closing delimiter
    send_frame(1'b1, 16'h42C1, 1'b0, 1'b0, 8, 1'b0);
    check_good(1'b1, 16'h42C1, "R11 back to back");

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      logic [18:0] v;
      v = VEC[i];
      send_frame(v[16], v[15:0], v[18], v[17], 8 + 4 * i, 1'b1);
      if (v[18:17] == 2'b00) begin
        check_good(v[16], v[15:0], v[16] ? "R4 reg frame" : "R3 dac frame");
      end else begin
        chk(parity_err_o && !frame_ok_o, "R5 parity slice", 32'({parity_err_o, frame_ok_o}), 32'h2);
        chk(!dac_we_o && !reg_we_o && !frame_err_o, "R6 no write on parity error",
            32'({dac_we_o, reg_we_o, frame_err_o}), 32'h0);
      end
    end

    // R7: short frame
    send_sym(2'd2, 8);
    for (int b = 0; b < 5; b++) send_sym(2'd1, 8);
    send_sym(2'd2, 8);
    chk(frame_err_o && !frame_ok_o && !parity_err_o, "R7 short frame",
        32'({frame_err_o, frame_ok_o, parity_err_o}), 32'h4);
    // R2: that delimiter opened an empty frame; another delimiter is quiet
    send_sym(2'd2, 8); strobes_quiet("R2 delim on empty buffer");

    // R7: long frame (20 bits)
    for (int b = 0; b < 20; b++) send_sym(2'd0, 8);
    send_sym(2'd2, 8);
    chk(frame_err_o && !parity_err_o, "R7 long frame", 32'({frame_err_o, parity_err_o}), 32'h2);

    // R7: invalid symbol inside a frame, then frame is closed
    for (int b = 0; b < 3; b++) send_sym(2'd1, 8);
    send_sym(2'd3, 8);
    chk(frame_err_o == 1'b1, "R7 invalid in frame", 32'(frame_err_o), 32'h1);
    send_sym(2'd1, 8); strobes_quiet("R7 frame closed by invalid");
    send_sym(2'd2, 8); strobes_quiet("R7 delim after invalid");

    // R8: acknowledge timing, P = 16 -> low cycles 5..28
    ack_en_i = 1'b1;
    send_frame(1'b0, 16'h0F0F, 1'b0, 1'b0, 16, 1'b0);
    check_good(1'b0, 16'h0F0F, "R8 frame");
    first = -1; lows = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (!ack_n_o) begin
        lows++;
        if (first < 0) first = k;
      end
    end
    chk(first == 5, "R8 ack start", 32'(first), 32'd5);
    chk(lows == 24, "R8 ack width", 32'(lows), 32'd24);

    // R9: disabled acknowledge
    ack_en_i = 1'b0;
    send_frame(1'b1, 16'h7711, 1'b0, 1'b0, 16, 1'b1);
    check_good(1'b1, 16'h7711, "R9 frame");
    lows = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (!ack_n_o) lows++;
    end
    chk(lows == 0, "R9 no ack", 32'(lows), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule